// File: doc/BRIEF.md
# Byte-Wide SPI Master Peripheral

This block is an SPI master attached to a small byte-wide register bus. Software writes a byte into a transmit register, issues a start command, and the block shifts that byte out on MOSI while it collects eight bits from MISO. There is no queue: each completed byte raises a receive-ready flag and an interrupt, and software has to read the result and start the next byte itself. Chip selects are driven by general-purpose pins elsewhere and are not part of this block.

The serial clock comes from a divider. The bus clock is divided by four times the divisor plus one, so a divisor of 0 gives a quarter of the bus rate and 255 gives 1/1024. A mode register sets the clock idle level, the sampling edge, the bit order and an internal loopback path. Its sampling-edge bit is the inverse of the usual phase setting: when set, data is latched on the leading edge. The busy flag stays high for one bus cycle after the receive-ready flag rises.

Top module: `spi_byte_master`

## Requirements
- R1: After reset the status register (offset 4) reads 0x00, the interrupt is low, SCLK is low and the mode register reads 0x00.
- R2: The mode register (offset 0, only bits 4:0 stored), the transmit register (offset 2) and the divisor register (offset 6) read back what was written. The control register (offset 3) and the reserved offset 5 read 0x00.
- R3: Writing a value with bit 0 set to the control register (offset 3) while the port is enabled (mode bit 3) and not busy starts exactly one transfer of the transmit register's byte. That transfer has exactly 8 SCLK pulses.
- R4: A start command is ignored while mode bit 3 is clear or while status bit 1 (busy) is set. No SCLK edge follows it, and the byte already in flight is unaffected.
- R5: SCLK rests at the level of mode bit 1 (1 = idle high) whenever no transfer is active. During a transfer its period is 4*(divisor+1) bus clocks.
- R6: With mode bit 4 set, the first data bit is on MOSI before the first SCLK edge, both sides sample on leading edges, and MOSI changes on trailing edges. With bit 4 clear, MOSI changes on leading edges and both sides sample on trailing edges.
- R7: Mode bit 2 set sends and assembles bits least significant first. Clear sends and assembles them most significant first.
- R8: With mode bit 0 set, the received byte is the transmitted byte whatever MISO carries.
- R9: When a byte completes, status bit 0 (receive ready) and the interrupt rise in the same cycle. Status bit 1 (busy) is still high in that cycle and low in the next.
- R10: A read of the receive register (offset 1) returns the received byte and clears receive-ready and the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; a read of offset 1 has a side effect |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Interrupt, high while a received byte is unread |

## Verification
The hardest situation to reach is a second start command that arrives while a byte is still shifting. Reaching it needs a slow divisor and a register write timed into the middle of the transfer. The bench gets there with a directed step. It rewrites the transmit register and strikes the control register a few dozen cycles after a launch. It then checks that the behavioural slave still captured the first byte and that exactly eight pulses occurred. Random transfers from a fixed seed vary the clock mode, bit order, loopback and divisor. Directed transfers cover divisors 0 and 255, and a behavioural slave measures the SCLK period at each one.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
  // register byte offsets
  localparam logic [2:0] OFS_MODE = 3'd0;
  localparam logic [2:0] OFS_RXD  = 3'd1;
  localparam logic [2:0] OFS_TXD  = 3'd2;
  localparam logic [2:0] OFS_CTRL = 3'd3;
  localparam logic [2:0] OFS_STAT = 3'd4;
  localparam logic [2:0] OFS_DIV  = 3'd6;

  // mode register bit positions
  localparam int MB_LOOP = 0;
  localparam int MB_CPOL = 1;
  localparam int MB_LSB  = 2;
  localparam int MB_EN   = 3;
  localparam int MB_LEAD = 4;
  localparam int MODE_W  = 5;

  typedef struct packed {
    logic lead;
    logic en;
    logic lsb;
    logic cpol;
    logic loop;
  } mode_t;
endpackage

// File: rtl/sbm_clkdiv.sv
module sbm_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam int CW = DIV_W + 1;

  // half period in bus clocks is 2*(div+1); counter wraps at this limit
  function automatic logic [CW-1:0] half_limit(input logic [DIV_W-1:0] d);
    return {d, 1'b1};
  endfunction

  logic [CW-1:0] cnt;
  logic          at_limit;

  assign at_limit = (cnt == half_limit(div));
  assign tick     = run && at_limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (!run || at_limit) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

  // R5: half period is at least two bus clocks
  assert_tick_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/sbm_shifter.sv
module sbm_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         tick,
  input  logic [W-1:0] tx_byte,
  input  logic         lead,
  input  logic         lsb,
  input  logic         cpol,
  input  logic         loop,
  input  logic         miso,
  output logic         active,
  output logic         done,
  output logic [W-1:0] rx_final,
  output logic         sclk,
  output logic         mosi
);
  localparam int EDGES = 2 * W;
  localparam int ECW   = $clog2(EDGES + 1);
  localparam int BCW   = $clog2(W + 1);

  function automatic logic pick_bit(input logic [W-1:0] b, input int idx, input logic lsb_first);
    return lsb_first ? b[idx] : b[W-1-idx];
  endfunction

  function automatic logic [W-1:0] shift_in(input logic [W-1:0] sr, input logic din, input logic lsb_first);
    return lsb_first ? {din, sr[W-1:1]} : {sr[W-2:0], din};
  endfunction

  logic           phase;
  logic [ECW-1:0] edge_cnt;
  logic [BCW-1:0] out_idx;
  logic [W-1:0]   tx_hold;
  logic [W-1:0]   rx_sr;
  logic           mosi_q;
  logic           edge_now, sample_now, drive_now, last_edge, din;
  logic [W-1:0]   rx_next;

  assign edge_now   = active && tick;
  // phase 0 -> 1 is a leading edge
  assign sample_now = edge_now && (lead ? !phase : phase);
  assign drive_now  = edge_now && (lead ? phase : !phase) && (out_idx < BCW'(W));
  assign last_edge  = edge_now && (edge_cnt == ECW'(EDGES - 1));
  assign din        = loop ? mosi_q : miso;
  assign rx_next    = shift_in(rx_sr, din, lsb);
  assign rx_final   = sample_now ? rx_next : rx_sr;
  assign done       = last_edge;
  assign sclk       = cpol ^ phase;
  assign mosi       = mosi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      phase    <= 1'b0;
      edge_cnt <= '0;
      out_idx  <= '0;
      tx_hold  <= '0;
      rx_sr    <= '0;
      mosi_q   <= 1'b0;
    end else if (start) begin
      active   <= 1'b1;
      phase    <= 1'b0;
      edge_cnt <= '0;
      tx_hold  <= tx_byte;
      rx_sr    <= '0;
      if (lead) begin
        mosi_q  <= pick_bit(tx_byte, 0, lsb);
        out_idx <= BCW'(1);
      end else begin
        out_idx <= '0;
      end
    end else if (edge_now) begin
      phase    <= ~phase;
      edge_cnt <= edge_cnt + 1'b1;
      if (sample_now) rx_sr <= rx_next;
      if (drive_now) begin
        mosi_q  <= pick_bit(tx_hold, int'(out_idx), lsb);
        out_idx <= out_idx + 1'b1;
      end
      if (last_edge) active <= 1'b0;
    end
  end

  // R5: clock rests at idle level outside a transfer
  assert_sclk_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (sclk == cpol));
  // R3: a launch enters the active state with no edge yet
  assert_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (active && sclk == cpol));
endmodule

// File: rtl/sbm_regs.sv
module sbm_regs
  import sbm_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    addr,
  input  logic          wr,
  input  logic          rd,
  input  logic [DW-1:0] wdata,
  input  logic          busy,
  input  logic          done,
  input  logic [DW-1:0] rx_byte,
  output logic [DW-1:0] rdata,
  output mode_t         mode,
  output logic [DW-1:0] txd,
  output logic [7:0]    div,
  output logic          start,
  output logic          rx_ready
);
  logic [DW-1:0] rxd;
  logic          rd_rxd;

  assign rd_rxd = rd && (addr == OFS_RXD);
  assign start  = wr && (addr == OFS_CTRL) && wdata[0] && mode.en && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode     <= '0;
      txd      <= '0;
      div      <= '0;
      rxd      <= '0;
      rx_ready <= 1'b0;
    end else begin
      if (wr && addr == OFS_MODE) mode <= mode_t'(wdata[MODE_W-1:0]);
      if (wr && addr == OFS_TXD)  txd  <= wdata;
      if (wr && addr == OFS_DIV)  div  <= wdata[7:0];
      if (done) begin
        rxd      <= rx_byte;
        rx_ready <= 1'b1;
      end else if (rd_rxd) begin
        rx_ready <= 1'b0;
      end
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      OFS_MODE: rdata = DW'(mode);
      OFS_RXD:  rdata = rxd;
      OFS_TXD:  rdata = txd;
      OFS_STAT: rdata = DW'({busy, rx_ready});
      OFS_DIV:  rdata = DW'(div);
      default:  rdata = '0;
    endcase
  end

  // R10: reading the receive register drops the ready flag
  assert_rx_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rxd && !done) |=> !rx_ready);
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
  import sbm_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DIV_W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          sclk,
  output logic          mosi,
  input  logic          miso,
  output logic          irq
);
  mode_t          mode;
  logic [DW-1:0]  txd;
  logic [7:0]     div;
  logic           start_cmd;
  logic           rx_ready;
  logic           xfer_active;
  logic           xfer_done;
  logic           div_tick;
  logic [DW-1:0]  rx_final;
  logic           busy_tail;
  logic           busy;

  assign busy = xfer_active || busy_tail;
  assign irq  = rx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_tail <= 1'b0;
    else        busy_tail <= xfer_done;
  end

  sbm_regs #(.DW(DW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (bus_addr),
    .wr       (bus_wr),
    .rd       (bus_rd),
    .wdata    (bus_wdata),
    .busy     (busy),
    .done     (xfer_done),
    .rx_byte  (rx_final),
    .rdata    (bus_rdata),
    .mode     (mode),
    .txd      (txd),
    .div      (div),
    .start    (start_cmd),
    .rx_ready (rx_ready)
  );

  sbm_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (xfer_active),
    .div   (DIV_W'(div)),
    .tick  (div_tick)
  );

  sbm_shifter #(.W(DW)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_cmd),
    .tick     (div_tick),
    .tx_byte  (txd),
    .lead     (mode.lead),
    .lsb      (mode.lsb),
    .cpol     (mode.cpol),
    .loop     (mode.loop),
    .miso     (miso),
    .active   (xfer_active),
    .done     (xfer_done),
    .rx_final (rx_final),
    .sclk     (sclk),
    .mosi     (mosi)
  );

  // R4: no launch follows a cycle with the port disabled
  assert_disabled_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mode.en |=> !$rose(xfer_active));
  // R4: no launch follows a busy cycle
  assert_busy_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !$rose(xfer_active));
  // R9: completion raises the interrupt
  assert_irq_on_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> irq);
  // R9: busy outlives the transfer by exactly one cycle
  assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xfer_active) |-> busy);
  assert_busy_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xfer_active) |=> !busy);
endmodule

// File: tb/sim_spi_byte_master.sv
module sim_spi_byte_master;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       sclk, mosi, irq;
  logic       miso = 1'b0;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  spi_byte_master u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sclk(sclk), .mosi(mosi), .miso(miso), .irq(irq)
  );

  // ---------------- bench functions ----------------
  function automatic int exp_period(input logic [7:0] d);
    return 4 * (int'(d) + 1);
  endfunction

  function automatic logic nth_bit(input logic [7:0] b, input int k, input logic lsb);
    if (lsb) return b[k];
    return b[7-k];
  endfunction

  function automatic logic [7:0] mode_byte(input logic lead, input logic en,
                                           input logic lsb, input logic cpol, input logic loop);
    return {3'b000, lead, en, lsb, cpol, loop};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // ---------------- behavioural slave ----------------
  logic       c_lead, c_cpol, c_lsb;
  logic [7:0] s_tx, s_rx;
  int         s_out, s_in, pulses, period_bad, last_lead, cyc;
  bit         armed = 0;
  bit         seen_lead;
  logic       prev_sclk = 1'b0;
  logic [7:0] cur_div;

  always @(posedge clk) cyc <= cyc + 1;
  initial cyc = 0;

  always @(negedge clk) begin
    if (armed && sclk !== prev_sclk) begin
      automatic logic leading = (sclk != c_cpol);
      if (leading) begin
        pulses++;
        if (seen_lead && (cyc - last_lead) != exp_period(cur_div)) period_bad++;
        seen_lead = 1;
        last_lead = cyc;
      end
      if (c_lead ? leading : !leading) begin
        s_rx = c_lsb ? {mosi, s_rx[7:1]} : {s_rx[6:0], mosi};
        s_in++;
      end else if (s_out < 8) begin
        miso = nth_bit(s_tx, s_out, c_lsb);
        s_out++;
      end
    end
    prev_sclk = sclk;
  end

  // ---------------- bus tasks ----------------
  task automatic bw(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic br(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(posedge clk);
    #1 bus_rd = 1'b0;
  endtask

  logic       x_loop;
  logic [7:0] x_tx, x_stx;

  task automatic start_xfer(input logic lead, input logic cpol, input logic lsb,
                            input logic loop, input logic [7:0] d,
                            input logic [7:0] tx, input logic [7:0] stx);
    bw(3'd0, mode_byte(lead, 1'b1, lsb, cpol, loop));
    bw(3'd6, d);
    bw(3'd2, tx);
    c_lead = lead; c_cpol = cpol; c_lsb = lsb; cur_div = d;
    x_loop = loop; x_tx = tx; x_stx = stx;
    s_tx = stx; s_rx = '0; s_in = 0; pulses = 0; period_bad = 0; seen_lead = 0;
    if (lead) begin miso = nth_bit(stx, 0, lsb); s_out = 1; end
    else s_out = 0;
    armed = 1;
    bw(3'd3, 8'h01);
  endtask

  task automatic finish_xfer(input string tag);
    logic [7:0] st1, st2, rd;
    while (!irq) @(negedge clk);
    bus_addr = 3'd4; bus_rd = 1'b1;
    #1 st1 = bus_rdata;
    @(negedge clk);
    #1 st2 = bus_rdata;
    bus_rd = 1'b0;
    chk({"R9 status at completion ", tag}, st1, 8'h03);
    chk({"R9 busy drops next cycle ", tag}, st2, 8'h01);
    chk({"R3 pulse count ", tag}, pulses, 8);
    chk({"R5 period violations ", tag}, period_bad, 0);
    chk({"R5 idle level ", tag}, sclk, c_cpol);
    chk({"R6 R7 slave captured ", tag}, s_rx, x_tx);
    br(3'd1, rd);
    chk({"R6 R7 R8 received byte ", tag}, rd, x_loop ? x_tx : x_stx);
    chk({"R10 irq cleared ", tag}, irq, 0);
    armed = 0;
  endtask

  // ---------------- main sequence ----------------
  initial begin
    logic [7:0] v;
    void'($urandom(32'h5EED_0C4A));
    repeat (3) @(negedge clk);
    // R1 reset state
    br(3'd4, v); chk("R1 status after reset", v, 8'h00);
    chk("R1 irq after reset", irq, 0);
    chk("R1 sclk after reset", sclk, 0);
    br(3'd0, v); chk("R1 mode after reset", v, 8'h00);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 register access
    bw(3'd0, 8'hFF); br(3'd0, v); chk("R2 mode keeps bits 4:0", v, 8'h1F);
    bw(3'd0, 8'h00);
    bw(3'd2, 8'hA5); br(3'd2, v); chk("R2 transmit readback", v, 8'hA5);
    bw(3'd6, 8'h3C); br(3'd6, v); chk("R2 divisor readback", v, 8'h3C);
    br(3'd3, v); chk("R2 control reads zero", v, 8'h00);
    br(3'd5, v); chk("R2 reserved reads zero", v, 8'h00);
    bw(3'd0, 8'h02); chk("R5 idle high follows mode", sclk, 1);

    // R4 start with port disabled
    pulses = 0; c_cpol = 1'b1; c_lead = 1'b0; c_lsb = 1'b0; cur_div = 8'd0;
    s_out = 8; armed = 1;
    bw(3'd3, 8'h01);
    repeat (60) @(negedge clk);
    br(3'd4, v); chk("R4 disabled start leaves status idle", v, 8'h00);
    chk("R4 disabled start gives no pulse", pulses, 0);
    armed = 0;

    // R6 all four clock modes, directed
    for (int m = 0; m < 4; m++) begin
      start_xfer(m[0], m[1], 1'b0, 1'b0, 8'd1, 8'h96 ^ 8'(m), 8'h3B + 8'(m));
      finish_xfer($sformatf("mode%0d", m));
    end
    // R7 LSB first, both phases
    start_xfer(1'b1, 1'b0, 1'b1, 1'b0, 8'd0, 8'h01, 8'h80);
    finish_xfer("lsb lead");
    start_xfer(1'b0, 1'b1, 1'b1, 1'b0, 8'd2, 8'hC4, 8'h1E);
    finish_xfer("lsb trail");
    // R8 loopback, MISO ignored
    start_xfer(1'b1, 1'b0, 1'b0, 1'b1, 8'd0, 8'h5A, 8'hFF);
    finish_xfer("loop");
    // R5 divisor boundaries
    start_xfer(1'b0, 1'b0, 1'b0, 1'b0, 8'd0, 8'hF0, 8'h0F);
    finish_xfer("div0");
    start_xfer(1'b1, 1'b1, 1'b0, 1'b0, 8'd255, 8'h69, 8'h2D);
    finish_xfer("div255");

    // R4 start while busy is ignored
    start_xfer(1'b1, 1'b0, 1'b0, 1'b0, 8'd3, 8'hB7, 8'h44);
    repeat (30) @(negedge clk);
    bw(3'd2, 8'h00);
    bw(3'd3, 8'h01);
    finish_xfer("busy restart");
    armed = 1; pulses = 0;
    repeat (80) @(negedge clk);
    chk("R4 no second transfer", pulses, 0);
    br(3'd4, v); chk("R4 status idle after ignored start", v, 8'h00);
    armed = 0;

    // random transfers
    for (int i = 0; i < 24; i++) begin
      automatic logic [31:0] r = $urandom;
      start_xfer(r[0], r[1], r[2], r[3], 8'(r[5:4]), r[15:8], r[23:16]);
      finish_xfer($sformatf("rand%0d", i));
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule